// File: doc/BRIEF.md
# Grouped Micro-op Chaining Sequencer

This block issues vector instructions to two pipelined functional units and chains dependent work between them. One unit is a two-stage convert pipe and the other a three-stage add pipe. Both accept one micro-op per cycle. Instructions reach the block in program order from a queue, after the scalar core has retired them. Each instruction names a destination base register, two source base registers and a group size L of 1, 2, 4 or 8. The sequencer expands it into L micro-ops on consecutive registers, one per cycle when nothing blocks it.

A per-register scoreboard records writes that are in flight. A consumer micro-op may issue in the same cycle that its producer's result sits in the producer unit's last stage, because the result is forwarded at that edge. Dependencies are tracked one register at a time. A consumer can therefore start on register k of a group while the producer is still working on later registers of the same group. The block carries register tags only. The datapath is outside it.

Each unit holds one instruction at a time. The newer of the two instructions also respects the older one's micro-ops that have not issued yet. It does not read or write a register that the older instruction still has to write, and it does not write a register that the older one still has to read.

Top module: `vseq_chain`

## Requirements
- R1: While reset is held and on the first cycle after it, with no queue entry offered, both issue strobes, both stage-valid vectors and vq_pop are 0.
- R2: An instruction with size code vq_lmul = c has L = 2^c micro-ops (code 0,1,2,3 gives 1,2,4,8). Micro-op k carries destination vd+k and sources vs1+k and vs2+k, modulo 32. When no hazard blocks them, micro-ops issue on consecutive cycles starting the cycle after the pop.
- R3: A micro-op that issues in cycle t sets bit 0 of its unit's stage-valid vector in cycle t+1 and bit i in cycle t+1+i. The convert vector has 2 bits and the add vector has 3. The last bit is the final stage.
- R4: A micro-op that reads or writes a register written by an earlier micro-op issues no sooner than the cycle in which that producer occupies its final stage. That is 2 cycles after a convert producer's issue and 3 cycles after an add producer's issue. It issues in exactly that cycle when nothing else blocks it.
- R5: The queue head is popped only when its target unit (vq_sel_add: 0 = convert, 1 = add) is idle or is issuing its last micro-op in that cycle. This lets back-to-back instructions on one unit issue without a gap.
- R6: Instructions on different units with no register overlap issue concurrently, so their micro-ops are in flight in the same cycles.
- R7: A newer instruction does not issue a micro-op that reads or writes any register of the older instruction's destination group whose micro-op has not issued yet.
- R8: A newer instruction does not issue a micro-op whose destination is a register that the older instruction has yet to read.
- R9: The final stages of the two units never hold micro-ops for the same destination register in the same cycle.
- R10: A stalled unit keeps presenting the same micro-op and resumes at that same index k once the hazard clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vq_valid | input | 1 | Queue head holds a retired vector instruction |
| vq_sel_add | input | 1 | Target unit: 0 convert, 1 add |
| vq_lmul | input | 2 | Group size code, L = 2^code |
| vq_vd | input | 5 | Destination base register |
| vq_vs1 | input | 5 | First source base register |
| vq_vs2 | input | 5 | Second source base register |
| vq_pop | output | 1 | Queue head taken this cycle |
| cv_issue | output | 1 | Convert micro-op issues this cycle |
| cv_vd | output | 5 | Convert micro-op destination |
| cv_vs1 | output | 5 | Convert micro-op first source |
| cv_vs2 | output | 5 | Convert micro-op second source |
| cv_stage_vld | output | 2 | Convert stage occupancy, bit 0 = X1 |
| ad_issue | output | 1 | Add micro-op issues this cycle |
| ad_vd | output | 5 | Add micro-op destination |
| ad_vs1 | output | 5 | Add micro-op first source |
| ad_vs2 | output | 5 | Add micro-op second source |
| ad_stage_vld | output | 3 | Add stage occupancy, bit 0 = X1 |

## Verification
The cycle-by-cycle properties cover several behaviours. They check that no consumer of a register issues one cycle after its convert producer, or one or two cycles after its add producer. They check that the final stages never collide on a destination, that a stalled unit holds its micro-op, and that a pop lands in the unit it names. Other behaviours need whole instruction pairs, so only the bench's scenarios show them. These are the exact cycle in which a chained group starts, the per-register overlap of an eight-register producer and consumer, and back-to-back dispatch on one unit. They also include the newer instruction waiting out the older one's unissued writes and reads, and concurrent issue on independent units.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  parameter int NREG = 32;
  parameter int MAX_LMUL_LOG2 = 3;
  localparam int RW = $clog2(NREG);
  localparam int CW = MAX_LMUL_LOG2 + 1;

  typedef logic [RW-1:0] vreg_t;
  typedef logic [CW-1:0] cnt_t;

  // group size from the 2-bit size code
  function automatic cnt_t grp_len(input logic [1:0] code);
    return cnt_t'(1) << code;
  endfunction

  // register r lies in the part of a group from index 'from' up to 'len'-1
  function automatic logic grp_hit(input vreg_t r, input vreg_t base,
                                   input cnt_t from, input cnt_t len);
    vreg_t off;
    off = r - base;
    return (int'(off) >= int'(from)) && (int'(off) < int'(len));
  endfunction

  // newer micro-op (y_*) collides with what the older instruction has left
  function automatic logic older_blocks(input vreg_t o_vd, input vreg_t o_vs1,
                                        input vreg_t o_vs2, input cnt_t o_cnt,
                                        input cnt_t o_len, input vreg_t y_vd,
                                        input vreg_t y_vs1, input vreg_t y_vs2);
    logic raw_waw, war;
    raw_waw = grp_hit(y_vd, o_vd, o_cnt, o_len) | grp_hit(y_vs1, o_vd, o_cnt, o_len)
            | grp_hit(y_vs2, o_vd, o_cnt, o_len);
    war     = grp_hit(y_vd, o_vs1, o_cnt, o_len) | grp_hit(y_vd, o_vs2, o_cnt, o_len);
    return raw_waw | war;
  endfunction
endpackage

// File: rtl/vseq_unit.sv
module vseq_unit
  import vseq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  vreg_t             ld_vd,
  input  vreg_t             ld_vs1,
  input  vreg_t             ld_vs2,
  input  cnt_t              ld_len,
  input  logic              go,
  output logic              busy,
  output logic              issue,
  output logic              last,
  output vreg_t             base_vd,
  output vreg_t             base_vs1,
  output vreg_t             base_vs2,
  output cnt_t              cnt,
  output cnt_t              len,
  output vreg_t             cur_vd,
  output vreg_t             cur_vs1,
  output vreg_t             cur_vs2,
  output logic [STAGES-1:0] stage_vld,
  output logic              tail_vld,
  output vreg_t             tail_vd
);
  vreg_t stage_vd [STAGES];

  assign cur_vd  = base_vd  + vreg_t'(cnt);
  assign cur_vs1 = base_vs1 + vreg_t'(cnt);
  assign cur_vs2 = base_vs2 + vreg_t'(cnt);
  assign issue   = busy && go;
  assign last    = busy && (cnt == len - cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      len      <= '0;
      base_vd  <= '0;
      base_vs1 <= '0;
      base_vs2 <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      cnt      <= '0;
      len      <= ld_len;
      base_vd  <= ld_vd;
      base_vs1 <= ld_vs1;
      base_vs2 <= ld_vs2;
    end else if (issue) begin
      cnt <= cnt + cnt_t'(1);
      if (last) busy <= 1'b0;
    end
  end

  // execute stage occupancy, one register per stage
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_vld[i] <= 1'b0;
        stage_vd[i]  <= '0;
      end else if (i == 0) begin
        stage_vld[i] <= issue;
        stage_vd[i]  <= cur_vd;
      end else begin
        stage_vld[i] <= stage_vld[(i == 0) ? 0 : i-1];
        stage_vd[i]  <= stage_vd[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign tail_vld = stage_vld[STAGES-1];
  assign tail_vd  = stage_vd[STAGES-1];
endmodule

// File: rtl/vseq_scoreboard.sv
module vseq_scoreboard
  import vseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_a,
  input  vreg_t           set_a_reg,
  input  logic            set_b,
  input  vreg_t           set_b_reg,
  input  logic            clr_a,
  input  vreg_t           clr_a_reg,
  input  logic            clr_b,
  input  vreg_t           clr_b_reg,
  output logic [NREG-1:0] pend
);
  logic [NREG-1:0] pend_nxt;

  // a set for a register beats a clear of the same register
  always_comb begin
    pend_nxt = pend;
    if (clr_a) pend_nxt[clr_a_reg] = 1'b0;
    if (clr_b) pend_nxt[clr_b_reg] = 1'b0;
    if (set_a) pend_nxt[set_a_reg] = 1'b1;
    if (set_b) pend_nxt[set_b_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/vseq_chain.sv
module vseq_chain
  import vseq_pkg::*;
#(
  parameter int CV_STAGES = 2,
  parameter int AD_STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vq_valid,
  input  logic                 vq_sel_add,
  input  logic [1:0]           vq_lmul,
  input  logic [RW-1:0]        vq_vd,
  input  logic [RW-1:0]        vq_vs1,
  input  logic [RW-1:0]        vq_vs2,
  output logic                 vq_pop,
  output logic                 cv_issue,
  output logic [RW-1:0]        cv_vd,
  output logic [RW-1:0]        cv_vs1,
  output logic [RW-1:0]        cv_vs2,
  output logic [CV_STAGES-1:0] cv_stage_vld,
  output logic                 ad_issue,
  output logic [RW-1:0]        ad_vd,
  output logic [RW-1:0]        ad_vs1,
  output logic [RW-1:0]        ad_vs2,
  output logic [AD_STAGES-1:0] ad_stage_vld
);
  logic  cv_busy, cv_last, cv_go, cv_load, cv_free, cv_yield, cv_tail_vld;
  logic  ad_busy, ad_last, ad_go, ad_load, ad_free, ad_yield, ad_tail_vld;
  vreg_t cv_bvd, cv_bvs1, cv_bvs2, cv_tail_vd;
  vreg_t ad_bvd, ad_bvs1, ad_bvs2, ad_tail_vd;
  cnt_t  cv_cnt, cv_len, ad_cnt, ad_len, q_len;
  logic  cv_older;
  logic [NREG-1:0] pend, fwd, hold;

  assign q_len = grp_len(vq_lmul);

  // registers whose producer sits in a final stage are forwarded this cycle
  always_comb begin
    fwd = '0;
    if (cv_tail_vld) fwd[cv_tail_vd] = 1'b1;
    if (ad_tail_vld) fwd[ad_tail_vd] = 1'b1;
  end
  assign hold = pend & ~fwd;

  assign cv_yield = ad_busy && !cv_older &&
                    older_blocks(ad_bvd, ad_bvs1, ad_bvs2, ad_cnt, ad_len, cv_vd, cv_vs1, cv_vs2);
  assign ad_yield = cv_busy && cv_older &&
                    older_blocks(cv_bvd, cv_bvs1, cv_bvs2, cv_cnt, cv_len, ad_vd, ad_vs1, ad_vs2);
  assign cv_go = !hold[cv_vd] && !hold[cv_vs1] && !hold[cv_vs2] && !cv_yield;
  assign ad_go = !hold[ad_vd] && !hold[ad_vs1] && !hold[ad_vs2] && !ad_yield;

  assign cv_free = !cv_busy || (cv_issue && cv_last);
  assign ad_free = !ad_busy || (ad_issue && ad_last);
  assign vq_pop  = vq_valid && (vq_sel_add ? ad_free : cv_free);
  assign cv_load = vq_pop && !vq_sel_add;
  assign ad_load = vq_pop && vq_sel_add;

  // age between the two resident instructions: the one loaded later is newer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cv_older <= 1'b0;
    else if (ad_load) cv_older <= 1'b1;
    else if (cv_load) cv_older <= 1'b0;
  end

  vseq_unit #(.STAGES(CV_STAGES)) u_cv (
    .clk(clk), .rst_n(rst_n), .load(cv_load), .ld_vd(vq_vd), .ld_vs1(vq_vs1),
    .ld_vs2(vq_vs2), .ld_len(q_len), .go(cv_go), .busy(cv_busy), .issue(cv_issue),
    .last(cv_last), .base_vd(cv_bvd), .base_vs1(cv_bvs1), .base_vs2(cv_bvs2),
    .cnt(cv_cnt), .len(cv_len), .cur_vd(cv_vd), .cur_vs1(cv_vs1), .cur_vs2(cv_vs2),
    .stage_vld(cv_stage_vld), .tail_vld(cv_tail_vld), .tail_vd(cv_tail_vd)
  );

  vseq_unit #(.STAGES(AD_STAGES)) u_ad (
    .clk(clk), .rst_n(rst_n), .load(ad_load), .ld_vd(vq_vd), .ld_vs1(vq_vs1),
    .ld_vs2(vq_vs2), .ld_len(q_len), .go(ad_go), .busy(ad_busy), .issue(ad_issue),
    .last(ad_last), .base_vd(ad_bvd), .base_vs1(ad_bvs1), .base_vs2(ad_bvs2),
    .cnt(ad_cnt), .len(ad_len), .cur_vd(ad_vd), .cur_vs1(ad_vs1), .cur_vs2(ad_vs2),
    .stage_vld(ad_stage_vld), .tail_vld(ad_tail_vld), .tail_vd(ad_tail_vd)
  );

  vseq_scoreboard u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_a(cv_issue), .set_a_reg(cv_vd), .set_b(ad_issue), .set_b_reg(ad_vd),
    .clr_a(cv_tail_vld), .clr_a_reg(cv_tail_vd), .clr_b(ad_tail_vld), .clr_b_reg(ad_tail_vd),
    .pend(pend)
  );
endmodule

// File: rtl/vseq_chain_chk.sv
module vseq_chain_chk
  import vseq_pkg::*;
#(
  parameter int CV_STAGES = 2,
  parameter int AD_STAGES = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 vq_pop,
  input logic                 vq_sel_add,
  input logic                 cv_issue,
  input logic [RW-1:0]        cv_vd,
  input logic [RW-1:0]        cv_vs1,
  input logic [RW-1:0]        cv_vs2,
  input logic [CV_STAGES-1:0] cv_stage_vld,
  input logic                 ad_issue,
  input logic [RW-1:0]        ad_vd,
  input logic [RW-1:0]        ad_vs1,
  input logic [RW-1:0]        ad_vs2,
  input logic [AD_STAGES-1:0] ad_stage_vld,
  input logic                 cv_busy,
  input logic                 ad_busy,
  input logic                 cv_last,
  input logic                 cv_tail_vld,
  input logic [RW-1:0]        cv_tail_vd,
  input logic                 ad_tail_vld,
  input logic [RW-1:0]        ad_tail_vd
);
  p_more_uops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cv_issue && !cv_last |=> cv_busy);

  p_cv_enters_x1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cv_issue |=> cv_stage_vld[0]);

  p_ad_enters_x1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ad_issue |=> ad_stage_vld[0]);

  // a convert result cannot be consumed one cycle after its producer issues
  p_cv_chain_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cv_issue |=> !(ad_issue && (ad_vs1 == $past(cv_vd) || ad_vs2 == $past(cv_vd) ||
                                ad_vd == $past(cv_vd))));

  // an add result needs three cycles before a same-unit consumer
  p_ad_chain_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_issue |=> ##1 !(ad_issue && (ad_vs1 == $past(ad_vd, 2) || ad_vs2 == $past(ad_vd, 2))));

  p_pop_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vq_pop && vq_sel_add |=> ad_busy);

  p_tails_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_tail_vld && ad_tail_vld && cv_tail_vd == ad_tail_vd));

  p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cv_busy && !cv_issue |=> cv_busy && $stable(cv_vd) && $stable(cv_vs1));
endmodule

bind vseq_chain vseq_chain_chk #(.CV_STAGES(CV_STAGES), .AD_STAGES(AD_STAGES)) u_chk (.*);

// File: tb/vseq_chain_tb.sv
module vseq_chain_tb;
  localparam int PERIOD = 10;
  localparam int NROW = 8;
  // a_add a_lm a_vd a_s1 a_s2 | b_add b_lm b_vd b_s1 b_s2 | first issue cycle of B
  localparam int ROWS [NROW][11] = '{
    '{0, 3,  8, 16, 16,  1, 3, 24,  8,  0,  3},
    '{0, 2,  0,  4,  4,  1, 2,  8, 12, 16,  2},
    '{1, 1,  2,  4,  6,  0, 1, 10,  2,  2,  4},
    '{0, 2,  0,  8,  8,  0, 1, 16, 20, 20,  5},
    '{1, 1,  4,  8, 10,  1, 0, 12,  4,  5,  5},
    '{0, 0,  3,  7,  7,  1, 0,  3,  1,  2,  3},
    '{1, 3,  8, 16, 24,  0, 0, 23,  0,  0,  9},
    '{0, 3,  0,  8,  8,  1, 0, 16,  7,  7, 10}
  };
  localparam string TAG [NROW] = '{"R4", "R6", "R4", "R5", "R10", "R9", "R8", "R7"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic vq_valid = 1'b0, vq_sel_add = 1'b0, vq_pop;
  logic [1:0] vq_lmul = '0;
  logic [4:0] vq_vd = '0, vq_vs1 = '0, vq_vs2 = '0;
  logic cv_issue, ad_issue;
  logic [4:0] cv_vd, cv_vs1, cv_vs2, ad_vd, ad_vs1, ad_vs2;
  logic [1:0] cv_stage_vld;
  logic [2:0] ad_stage_vld;

  int checks = 0, errors = 0, cyc = 0;
  int row = 0, c0 = 0, mon_on = 0;
  int a_unit, a_len, a_seen, a_vd, a_s1, a_s2;
  int b_unit, b_len, b_seen, b_vd, b_s1, b_s2, b_start;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vseq_chain u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic see_uop(input int u, input int vd, input int s1, input int s2);
    int rel = cyc - c0;
    if (u == a_unit && a_seen < a_len) begin
      chk(rel == 1 + a_seen, "R2 A issue cycle", rel, 1 + a_seen);
      chk(vd == (a_vd + a_seen) % 32 && s1 == (a_s1 + a_seen) % 32 && s2 == (a_s2 + a_seen) % 32,
          "R2 A regs vd", vd, (a_vd + a_seen) % 32);
      a_seen++;
    end else if (u == b_unit && b_seen < b_len) begin
      chk(rel == b_start + b_seen, {TAG[row], " B issue cycle"}, rel, b_start + b_seen);
      chk(vd == (b_vd + b_seen) % 32 && s1 == (b_s1 + b_seen) % 32 && s2 == (b_s2 + b_seen) % 32,
          {TAG[row], " B regs vd"}, vd, (b_vd + b_seen) % 32);
      b_seen++;
    end else chk(1'b0, "R2 unexpected micro-op on unit", u, -1);
  endtask

  always @(negedge clk) begin
    if (mon_on != 0) begin
      if (cv_issue) see_uop(0, int'(cv_vd), int'(cv_vs1), int'(cv_vs2));
      if (ad_issue) see_uop(1, int'(ad_vd), int'(ad_vs1), int'(ad_vs2));
    end
  end

  task automatic offer(input int add, input int lm, input int vd, input int s1, input int s2);
    @(posedge clk); #1;
    vq_valid = 1'b1; vq_sel_add = add[0]; vq_lmul = 2'(lm);
    vq_vd = 5'(vd); vq_vs1 = 5'(s1); vq_vs2 = 5'(s2);
  endtask

  task automatic wait_pop();
    do @(negedge clk); while (!vq_pop);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cv_issue && !ad_issue && vq_pop == 1'b0, "R1 quiet in reset", int'(cv_issue) + int'(ad_issue), 0);
    chk(cv_stage_vld == '0 && ad_stage_vld == '0, "R1 stages empty in reset",
        int'(cv_stage_vld) + int'(ad_stage_vld), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!cv_issue && !ad_issue && !vq_pop && cv_stage_vld == '0 && ad_stage_vld == '0,
        "R1 idle after reset", int'(cv_issue) + int'(ad_issue) + int'(vq_pop), 0);

    // table of instruction pairs
    for (int i = 0; i < NROW; i++) begin
      row = i;
      a_unit = ROWS[i][0]; a_len = 1 << ROWS[i][1]; a_vd = ROWS[i][2];
      a_s1 = ROWS[i][3]; a_s2 = ROWS[i][4]; a_seen = 0;
      b_unit = ROWS[i][5]; b_len = 1 << ROWS[i][6]; b_vd = ROWS[i][7];
      b_s1 = ROWS[i][8]; b_s2 = ROWS[i][9]; b_start = ROWS[i][10]; b_seen = 0;
      mon_on = 1;
      offer(a_unit, ROWS[i][1], a_vd, a_s1, a_s2);
      c0 = cyc;
      wait_pop();
      offer(b_unit, ROWS[i][6], b_vd, b_s1, b_s2);
      wait_pop();
      @(posedge clk); #1 vq_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(a_seen == a_len, "R2 A micro-op count", a_seen, a_len);
      chk(b_seen == b_len, {TAG[i], " B micro-op count"}, b_seen, b_len);
      mon_on = 0;
    end

    // directed: stage occupancy of one add micro-op
    offer(1, 0, 20, 21, 22);
    @(negedge clk);
    chk(vq_pop == 1'b1 && !ad_issue, "R5 pop on idle unit", int'(vq_pop), 1);
    @(posedge clk); #1 vq_valid = 1'b0;
    @(negedge clk);
    chk(ad_issue && ad_vd == 5'd20, "R2 single issue", int'(ad_issue), 1);
    chk(ad_stage_vld == 3'b000, "R3 add stages at issue", int'(ad_stage_vld), 0);
    @(negedge clk);
    chk(ad_stage_vld == 3'b001, "R3 add X1", int'(ad_stage_vld), 1);
    @(negedge clk);
    chk(ad_stage_vld == 3'b010, "R3 add X2", int'(ad_stage_vld), 2);
    @(negedge clk);
    chk(ad_stage_vld == 3'b100 && cv_stage_vld == 2'b00, "R3 add X3", int'(ad_stage_vld), 4);
    @(negedge clk);
    chk(ad_stage_vld == 3'b000, "R3 add drained", int'(ad_stage_vld), 0);

    // directed: one convert micro-op
    offer(0, 0, 30, 31, 31);
    @(posedge clk); #1 vq_valid = 1'b0;
    @(negedge clk);
    chk(cv_issue && cv_vd == 5'd30, "R2 convert single issue", int'(cv_issue), 1);
    @(negedge clk);
    chk(cv_stage_vld == 2'b01, "R3 convert X1", int'(cv_stage_vld), 1);
    @(negedge clk);
    chk(cv_stage_vld == 2'b10, "R3 convert X2", int'(cv_stage_vld), 2);
    @(negedge clk);
    chk(cv_stage_vld == 2'b00, "R3 convert drained", int'(cv_stage_vld), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule